// File: doc/BRIEF.md
# Power-Supply Event Interrupt Unit

This unit collects four supply-health events for a small microcontroller and merges them into one level interrupt request. The events are: the switched rail moving from the main supply to the battery, the rail moving back to the main supply, the DC input comparator reporting a low input, and a line-voltage sag. Each event has a sticky flag and an enable bit. Both sit in byte-wide special-function registers on a simple register bus. Read data is combinational from the address, and a write takes effect at the clock edge where `bus_wr` is high.

The switch-state and comparator inputs are asynchronous. Each passes through a synchronizer, and an edge detector on the synchronized level produces the events. A read-only live bit shows which source feeds the rail at present.

Line-voltage magnitude samples arrive as a valid/ready stream. Each beat carries a magnitude and a zero-crossing marker. `smp_ready` is held high at all times, so the producer never sees back-pressure, and a beat is taken at every clock edge where `smp_valid` is high. A sag qualifier counts zero crossings that arrive while the magnitude stays below a programmable level. When the count reaches a programmable number of line cycles, it raises the sag event once.

Top module: `psu_event_irq`

## Requirements
- R1: After reset, all flags, all enables, the sag level and the sag cycle count read 0, the live bit reads 0 and `irq` is low.
- R2: Flag bit 0 of the flag register (address 0xF8) is set when the synchronized `rail_on_batt` input rises, meaning the rail moved from the main supply to the battery.
- R3: Flag bit 1 of 0xF8 is set when the synchronized `rail_on_batt` input falls, meaning the rail returned to the main supply.
- R4: Bit 6 of the configuration register (address 0xF4) follows `rail_on_batt` through the synchronizer: it reads 1 while the rail is on the battery and 0 while the rail is on the main supply. The other bits of 0xF4 read 0, and writes to 0xF4 have no effect.
- R5: Flag bit 2 of 0xF8 is set when the synchronized `dcin_low` input rises.
- R6: Flag bit 3 of 0xF8 is set when the count of beats that have `smp_zc`=1 and a magnitude below the level register (0xE4) reaches the cycle register (0xE5). A cycle value of 0 behaves like 1. Any beat with a magnitude at or above the level resets the count.
- R7: A sag raises the sag event only once. The event cannot fire again until a beat at or above the level has been seen.
- R8: A flag is set by its event whatever the state of its enable bit.
- R9: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R10: If an event and a write of 0 to its flag happen at the same clock edge, the flag ends up set.
- R11: `irq` is high exactly while at least one flag bit and its enable bit (address 0xEC, same bit position) are both 1.
- R12: The enable register 0xEC holds bits 3:0, and bits 7:4 read 0. The registers 0xE4 and 0xE5 read back what was written. All unmapped addresses read 0.
- R13: `smp_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| rail_on_batt | input | 1 | Asynchronous: the rail is fed from the battery |
| dcin_low | input | 1 | Asynchronous: the DC input is below its threshold |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample beat accepted, always 1 |
| smp_mag | input | DW | Line-voltage magnitude |
| smp_zc | input | 1 | The beat marks a zero crossing |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with its defaults: an 8-bit data width and a two-stage synchronizer. This makes the fixed synchronizer latency easy to count. With it, the bench can line up a comparator edge with a software clear at the same clock edge and check that the event wins. The 8-bit level and cycle registers let short sag sequences reach the counting boundaries. These include the exact count, a count broken by a beat at or above the level, a sample equal to the level, and the single firing within one long sag.

// File: rtl/psu_irq_pkg.sv
package psu_irq_pkg;
  localparam logic [7:0] ADDR_FLAGS  = 8'hF8;
  localparam logic [7:0] ADDR_EN     = 8'hEC;
  localparam logic [7:0] ADDR_CFG    = 8'hF4;
  localparam logic [7:0] ADDR_SAGLVL = 8'hE4;
  localparam logic [7:0] ADDR_SAGCYC = 8'hE5;
  localparam int NUM_EV   = 4;
  localparam int EV_BSO   = 0;
  localparam int EV_RST   = 1;
  localparam int EV_DCL   = 2;
  localparam int EV_SAG   = 3;
  localparam int LIVE_BIT = 6;
endpackage

// File: rtl/psu_sync.sv
module psu_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/psu_edge_det.sv
module psu_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/psu_sag_qual.sv
module psu_sag_qual #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic [W-1:0] mag,
  input  logic         zc,
  input  logic [W-1:0] level,
  input  logic [W-1:0] cycles,
  output logic         sag_evt
);
  logic [W-1:0] cnt_q;
  logic         done_q;
  logic [W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      sag_evt <= 1'b0;
    end else begin
      sag_evt <= 1'b0;
      if (beat) begin
        if (mag >= level) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else if (zc && !done_q) begin
          if (cnt_nxt >= {1'b0, cycles}) begin
            sag_evt <= 1'b1;
            done_q  <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_nxt[W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/psu_regs.sv
module psu_regs
  import psu_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NUM_EV-1:0] evt,
  input  logic              live,
  output logic [NUM_EV-1:0] flags,
  output logic [NUM_EV-1:0] en,
  output logic [DW-1:0]     sag_level,
  output logic [DW-1:0]     sag_cycles
);
  localparam int PADW = DW - NUM_EV;

  logic flag_wr;
  assign flag_wr = wr && (addr == ADDR_FLAGS);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flags[i] <= 1'b0;
      else if (evt[i])            flags[i] <= 1'b1;
      else if (flag_wr && !wdata[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= '0;
      sag_level  <= '0;
      sag_cycles <= '0;
    end else if (wr) begin
      if (addr == ADDR_EN)     en         <= wdata[NUM_EV-1:0];
      if (addr == ADDR_SAGLVL) sag_level  <= wdata;
      if (addr == ADDR_SAGCYC) sag_cycles <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_FLAGS:  rdata = {{PADW{1'b0}}, flags};
      ADDR_EN:     rdata = {{PADW{1'b0}}, en};
      ADDR_CFG:    rdata[LIVE_BIT] = live;
      ADDR_SAGLVL: rdata = sag_level;
      ADDR_SAGCYC: rdata = sag_cycles;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/psu_event_irq.sv
module psu_event_irq
  import psu_irq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rail_on_batt,
  input  logic          dcin_low,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_mag,
  input  logic          smp_zc,
  output logic          irq
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0]  lvl_s, lvl_rise, lvl_fall;
  logic              live_q;
  logic              sag_evt;
  logic [NUM_EV-1:0] evt;
  logic [NUM_EV-1:0] flags_q, en_q;
  logic [DW-1:0]     sag_level, sag_cycles;

  psu_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({dcin_low, rail_on_batt}), .dout(lvl_s)
  );

  psu_edge_det #(.W(NSYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .rise(lvl_rise), .fall(lvl_fall)
  );

  assign smp_ready = 1'b1;

  psu_sag_qual #(.W(DW)) u_sag (
    .clk(clk), .rst_n(rst_n), .beat(smp_valid && smp_ready), .mag(smp_mag),
    .zc(smp_zc), .level(sag_level), .cycles(sag_cycles), .sag_evt(sag_evt)
  );

  assign live_q       = lvl_s[0];
  assign evt[EV_BSO]  = lvl_rise[0];
  assign evt[EV_RST]  = lvl_fall[0];
  assign evt[EV_DCL]  = lvl_rise[1];
  assign evt[EV_SAG]  = sag_evt;

  psu_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rdata(bus_rdata), .evt(evt), .live(live_q), .flags(flags_q), .en(en_q),
    .sag_level(sag_level), .sag_cycles(sag_cycles)
  );

  assign irq = |(flags_q & en_q);
endmodule

// File: rtl/psu_irq_chk.sv
module psu_irq_chk
  import psu_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq,
  input logic              smp_valid,
  input logic              sag_evt,
  input logic              live,
  input logic [NUM_EV-1:0] flags,
  input logic [NUM_EV-1:0] en
);
  logic flag_wr;
  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAGS);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags))); // R9
  AST_W1_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && (&bus_wdata[NUM_EV-1:0])) |=> ((flags & $past(flags)) == $past(flags))); // R9
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq); // R11
  AST_BSO_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |=> flags[EV_BSO]); // R2
  AST_RST_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live) |=> flags[EV_RST]); // R3
  AST_SAG_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    sag_evt |-> $past(smp_valid)); // R6
  AST_SAG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sag_evt |=> flags[EV_SAG]); // R8
endmodule

bind psu_event_irq psu_irq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq(irq), .smp_valid(smp_valid), .sag_evt(sag_evt),
  .live(live_q), .flags(flags_q), .en(en_q)
);

// File: tb/sim_psu_event_irq.sv
module sim_psu_event_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rail_on_batt = 1'b0;
  logic       dcin_low = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] smp_mag = 8'h00;
  logic       smp_zc = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  psu_event_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rail_on_batt(rail_on_batt),
    .dcin_low(dcin_low), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_mag(smp_mag), .smp_zc(smp_zc), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic beat(logic [7:0] m, logic z);
    @(negedge clk);
    smp_valid = 1'b1; smp_mag = m; smp_zc = z;
    @(negedge clk);
    smp_valid = 1'b0; smp_zc = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'hF8, d); chk("R1 flags", d, 8'h00);
    rd(8'hEC, d); chk("R1 enables", d, 8'h00);
    rd(8'hE4, d); chk("R1 level", d, 8'h00);
    rd(8'hE5, d); chk("R1 cycles", d, 8'h00);
    rd(8'hF4, d); chk("R1 live", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R13 ready", {7'd0, smp_ready}, 8'h01);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(8'hEC, 8'hFF); rd(8'hEC, d); chk("R12 enable width", d, 8'h0F);
    wr(8'hEC, 8'h00);
    wr(8'hE4, 8'hA5); rd(8'hE4, d); chk("R12 level readback", d, 8'hA5);
    wr(8'hE5, 8'h3C); rd(8'hE5, d); chk("R12 cycles readback", d, 8'h3C);
    wr(8'hF4, 8'hFF); rd(8'hF4, d); chk("R4 cfg write ignored", d, 8'h00);
    wr(8'h10, 8'h77); rd(8'h10, d); chk("R12 unmapped", d, 8'h00);
  endtask

  task automatic t_switch();
    logic [7:0] d;
    @(negedge clk); rail_on_batt = 1'b1;
    settle();
    rd(8'hF8, d); chk("R2 switchover flag (R8 no enable)", d, 8'h01);
    rd(8'hF4, d); chk("R4 live on battery", d, 8'h40);
    wr(8'hF8, 8'hFF); rd(8'hF8, d); chk("R9 write 1 keeps", d, 8'h01);
    wr(8'hF8, 8'h00); rd(8'hF8, d); chk("R9 write 0 clears", d, 8'h00);
    @(negedge clk); rail_on_batt = 1'b0;
    settle();
    rd(8'hF8, d); chk("R3 restore flag", d, 8'h02);
    rd(8'hF4, d); chk("R4 live on main", d, 8'h00);
    wr(8'hF8, 8'h00);
  endtask

  task automatic t_dcin_race();
    logic [7:0] d;
    @(negedge clk); dcin_low = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_addr = 8'hF8; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'hF8, d); chk("R10 event beats clear / R5 dcin flag", d, 8'h04);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(8'hEC, 8'h04); #1 chk("R11 irq enabled+set", {7'd0, irq}, 8'h01);
    wr(8'hEC, 8'h0B); #1 chk("R11 irq other enables", {7'd0, irq}, 8'h00);
    wr(8'hEC, 8'h04);
    wr(8'hF8, 8'h00);
    rd(8'hF8, d); chk("R5 no re-set while held low", d, 8'h00);
    chk("R11 irq drops after clear", {7'd0, irq}, 8'h00);
    @(negedge clk); dcin_low = 1'b0;
    settle();
    wr(8'hEC, 8'h00);
  endtask

  task automatic t_sag();
    logic [7:0] d;
    wr(8'hE4, 8'h40); wr(8'hE5, 8'h03);
    beat(8'h10, 1'b1); beat(8'h10, 1'b1); beat(8'h10, 1'b0);
    settle(); rd(8'hF8, d); chk("R6 two cycles not enough", d, 8'h00);
    beat(8'h10, 1'b1);
    settle(); rd(8'hF8, d); chk("R6 sag after three cycles", d, 8'h08);
    wr(8'hF8, 8'h00);
    beat(8'h10, 1'b1); beat(8'h10, 1'b1); beat(8'h10, 1'b1); beat(8'h10, 1'b1);
    settle(); rd(8'hF8, d); chk("R7 fires once per sag", d, 8'h00);
    beat(8'h40, 1'b1);
    beat(8'h3F, 1'b1); beat(8'h3F, 1'b1);
    beat(8'h90, 1'b0);
    beat(8'h3F, 1'b1); beat(8'h3F, 1'b1);
    settle(); rd(8'hF8, d); chk("R6 high sample resets count", d, 8'h00);
    beat(8'h3F, 1'b1);
    settle(); rd(8'hF8, d); chk("R7 rearmed after level", d, 8'h08);
    wr(8'hF8, 8'h00);
    wr(8'hE5, 8'h00); beat(8'h50, 1'b0); beat(8'h01, 1'b1);
    settle(); rd(8'hF8, d); chk("R6 zero cycles acts as one", d, 8'h08);
    wr(8'hF8, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_switch();
    t_dcin_race();
    t_irq();
    t_sag();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule